// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running counter driven through a prescaler, with a small bank of compare channels. A prescale counter runs from zero up to a programmed limit. Each time it reaches the limit it returns to zero and the main counter advances by one. Every compare channel watches the value that the counter is about to take. When they agree, the channel can do any mix of three things: latch an interrupt flag, force the counter back to zero, or clear the run bit.

Software reaches the block through a flat register port. Writes are sampled on the clock edge and reads are combinational. With no compare actions enabled, the block serves as a continuous time base. With a compare value of 1 and all three actions on, it gives a one-shot delay whose length is set by the prescale limit.

Register word addresses: 0 control (bit 0 run, bit 1 clear-hold), 1 prescale limit, 2 prescale count (read-only), 3 counter value, 4 compare actions, 5 interrupt flags, 8+k compare value of channel k. In the compare-action register, channel k owns bits 3k (flag), 3k+1 (zero counter) and 3k+2 (stop).

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 1 is set, the counter and the prescale count are held at zero. A write that sets bit 1 takes priority over a compare hit in the same cycle, so that hit has no effect.
- R3: With run set and prescale limit P, the counter advances once every P+1 clocks, and every clock when P is 0. A step happens when the prescale count is at or above P, and the prescale count then returns to zero.
- R4: The 32-bit counter wraps from all ones to zero when no compare action zeroes it.
- R5: When a step gives a value equal to compare value k and bit 3k is set, interrupt flag bit k is set.
- R6: When a step hits channel k and bit 3k+1 is set, the counter becomes zero instead of the compare value.
- R7: When a step hits channel k and bit 3k+2 is set, control bit 0 is cleared and counting stops.
- R8: Writing a 1 to a bit of the interrupt flag register (address 5) clears that bit. Writing 0 leaves it unchanged. A hit in the same cycle wins.
- R9: `irq` is high whenever any flag bit is set, and stays high until software clears the flags.
- R10: Writing zero to the control register stops counting and keeps the counter value.
- R11: With compare value 1, all three actions on and prescale limit P, starting from zero, the flag is set P+1 clocks after run takes effect. The counter then reads 0 and control reads 0.
- R12: A write to address 3 loads the counter on the next edge. During that edge no step takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| irq | output | 1 | Interrupt, OR of the flag bits |

## Verification
The bench aims at the edge where a step and a software write collide. A design that let a compare hit win over a clear-hold write would raise a spurious interrupt. A design that compared the old counter value instead of the next one would fire one step late, and the one-shot would stretch by a full prescale period.

Other targets are the wrap from all ones, a prescale limit of zero, and a write of 0 to the flag register. A design that got the wrap wrong would stall or jump. One that mishandled a limit of zero would skip or double steps. One that treated a write of 0 as a clear would drop pending interrupts.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESCALE = 4'd1;
  localparam logic [ADDR_W-1:0] A_PCOUNT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_COUNT    = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCTL     = 4'd4;
  localparam logic [ADDR_W-1:0] A_ISTAT    = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0   = 4'd8;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearAll;  // zero both counters
    logic loadCnt;   // load counter from write data
    logic runCnt;    // counting allowed this cycle
    logic wrapZero;  // a hit asks the counter to go to zero
  } dpStrobe_t;
endpackage

// File: rtl/ptmr_datapath.sv
`timescale 1ns/1ps
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 32,
  parameter int NUM_MATCH = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  dpStrobe_t                           strb,
  input  logic [CNT_W-1:0]                    loadVal,
  input  logic [PRE_W-1:0]                    preLimit,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]     matchVal,
  output logic [NUM_MATCH-1:0]                hitVec,
  output logic [CNT_W-1:0]                    countVal,
  output logic [PRE_W-1:0]                    preCount
);
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] preCnt;
  logic             tickNow;
  logic [CNT_W-1:0] nextCnt;

  assign tickNow = strb.runCnt && (preCnt >= preLimit);
  assign nextCnt = cnt + CNT_W'(1);

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
    assign hitVec[k] = tickNow && (nextCnt == matchVal[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
    end else if (strb.clearAll) begin
      cnt    <= '0;
      preCnt <= '0;
    end else if (strb.loadCnt) begin
      cnt <= loadVal;
    end else if (strb.runCnt) begin
      if (tickNow) begin
        preCnt <= '0;
        cnt    <= strb.wrapZero ? '0 : nextCnt;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign countVal = cnt;
  assign preCount = preCnt;

  // R2: a clear strobe leaves both counters at zero
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (countVal == '0 && preCount == '0));
  // R3: no step, no change of the counter
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearAll && !strb.loadCnt && !tickNow) |=> $stable(countVal));
  // R4: all ones steps to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickNow && !strb.wrapZero && countVal == '1) |=> countVal == '0);
  // R6: zero-on-hit
  a_r6_zero_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (tickNow && strb.wrapZero) |=> countVal == '0);
  // R12: load lands next edge
  a_r12_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCnt && !strb.clearAll) |=> countVal == $past(loadVal));
endmodule

// File: rtl/ptmr_ctrl.sv
`timescale 1ns/1ps
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 32,
  parameter int NUM_MATCH = 2,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]                regWrData,
  input  logic [NUM_MATCH-1:0]             hitVec,
  input  logic [CNT_W-1:0]                 countVal,
  input  logic [PRE_W-1:0]                 preCount,
  output dpStrobe_t                        strb,
  output logic [CNT_W-1:0]                 loadVal,
  output logic [PRE_W-1:0]                 preLimit,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]  matchVal,
  output logic [DATA_W-1:0]                regRdData,
  output logic                             irq
);
  localparam int MCTL_W = 3 * NUM_MATCH;

  logic                 ctrlRun, ctrlClr;
  logic [PRE_W-1:0]     preReg;
  logic [MCTL_W-1:0]    mctl;
  logic [NUM_MATCH-1:0] intStat;
  logic [NUM_MATCH-1:0] irqSel, rstSel, stopSel, wrMatch;
  logic                 wrCtrl, wrPre, wrCount, wrMctl, wrIstat;
  logic [NUM_MATCH-1:0] clrMask;

  assign wrCtrl  = regWrEn && regAddr == A_CTRL;
  assign wrPre   = regWrEn && regAddr == A_PRESCALE;
  assign wrCount = regWrEn && regAddr == A_COUNT;
  assign wrMctl  = regWrEn && regAddr == A_MCTL;
  assign wrIstat = regWrEn && regAddr == A_ISTAT;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_chan
    assign irqSel[k]  = mctl[3*k];
    assign rstSel[k]  = mctl[3*k+1];
    assign stopSel[k] = mctl[3*k+2];
    assign wrMatch[k] = regWrEn && regAddr == (A_MATCH0 + ADDR_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           matchVal[k] <= '0;
      else if (wrMatch[k]) matchVal[k] <= regWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.clearAll = ctrlClr || (wrCtrl && regWrData[1]);
    strb.loadCnt  = wrCount;
    strb.runCnt   = ctrlRun && !strb.clearAll && !wrCount;
    strb.wrapZero = |(hitVec & rstSel);
  end
  assign loadVal  = regWrData[CNT_W-1:0];
  assign preLimit = preReg;
  assign clrMask  = wrIstat ? regWrData[NUM_MATCH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlRun <= 1'b0;
      ctrlClr <= 1'b0;
      preReg  <= '0;
      mctl    <= '0;
      intStat <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlRun <= regWrData[0];
        ctrlClr <= regWrData[1];
      end else if (|(hitVec & stopSel)) begin
        ctrlRun <= 1'b0;
      end
      if (wrPre)  preReg <= regWrData[PRE_W-1:0];
      if (wrMctl) mctl   <= regWrData[MCTL_W-1:0];
      intStat <= (intStat & ~clrMask) | (hitVec & irqSel);
    end
  end

  assign irq = |intStat;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:     regRdData = DATA_W'({ctrlClr, ctrlRun});
      A_PRESCALE: regRdData = DATA_W'(preReg);
      A_PCOUNT:   regRdData = DATA_W'(preCount);
      A_COUNT:    regRdData = DATA_W'(countVal);
      A_MCTL:     regRdData = DATA_W'(mctl);
      A_ISTAT:    regRdData = DATA_W'(intStat);
      default: begin
        for (int k = 0; k < NUM_MATCH; k++)
          if (regAddr == (A_MATCH0 + ADDR_W'(k))) regRdData = DATA_W'(matchVal[k]);
      end
    endcase
  end

  // R7: a stop hit clears run unless software writes control
  a_r7_stop: assert property (@(posedge clk) disable iff (!rstN)
    (|(hitVec & stopSel) && !wrCtrl) |=> !ctrlRun);
  // R8: written ones clear their flags when no hit competes
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrIstat && hitVec == '0) |=> (intStat & $past(regWrData[NUM_MATCH-1:0])) == '0);
  // R9: interrupt stays up until a flag write
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrIstat) |=> irq);
  // R10: writing zero to control stops counting
  a_r10_halt: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[1:0] == 2'b00) |=> !ctrlRun);
endmodule

// File: rtl/prescaled_match_timer.sv
`timescale 1ns/1ps
module prescaled_match_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 32,
  parameter int NUM_MATCH = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  dpStrobe_t                       strb;
  logic [CNT_W-1:0]                loadVal;
  logic [PRE_W-1:0]                preLimit;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_MATCH-1:0]            hitVec;
  logic [CNT_W-1:0]                countVal;
  logic [PRE_W-1:0]                preCount;

  ptmr_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NUM_MATCH(NUM_MATCH), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hitVec(hitVec), .countVal(countVal),
    .preCount(preCount), .strb(strb), .loadVal(loadVal),
    .preLimit(preLimit), .matchVal(matchVal), .regRdData(regRdData),
    .irq(irq)
  );

  ptmr_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NUM_MATCH(NUM_MATCH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .preLimit(preLimit), .matchVal(matchVal), .hitVec(hitVec),
    .countVal(countVal), .preCount(preCount)
  );

  // R1: interrupt low on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irq);
endmodule

// File: tb/prescaled_match_timer_bench.sv
`timescale 1ns/1ps
module prescaled_match_timer_bench;
  localparam int NM = 2;
  localparam logic [3:0] A_CTRL = 4'd0, A_PRE = 4'd1, A_PCNT = 4'd2,
                         A_CNT = 4'd3, A_MCTL = 4'd4, A_IST = 4'd5, A_M0 = 4'd8, A_M1 = 4'd9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = A_CNT;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int    errors = 0;
  int    checks = 0;
  string curTag = "R1";
  bit    started = 1'b0;
  bit    done = 1'b0;

  // reference state
  bit [31:0] mPre = 0, mPc = 0, mCnt = 0;
  bit        mRun = 0, mClr = 0;
  bit [5:0]  mMc = 0;
  bit [1:0]  mInt = 0;
  bit [31:0] mMatch [NM];

  prescaled_match_timer u_prescaled_match_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin : model
    bit wrC, clr, ld, runNow, tick;
    bit [1:0] hit;
    bit [31:0] nx;
    started = 1'b1;
    if (!rstN) begin
      mPre = 0; mPc = 0; mCnt = 0; mRun = 0; mClr = 0; mMc = 0; mInt = 0;
      for (int k = 0; k < NM; k++) mMatch[k] = 0;
    end else begin
      wrC    = regWrEn && regAddr == A_CTRL;
      clr    = mClr || (wrC && regWrData[1]);
      ld     = regWrEn && regAddr == A_CNT;
      runNow = mRun && !clr && !ld;
      tick   = runNow && (mPc >= mPre);
      nx     = mCnt + 1;
      hit    = 0;
      for (int k = 0; k < NM; k++) if (tick && nx == mMatch[k]) hit[k] = 1'b1;
      if (clr) begin
        mPc = 0; mCnt = 0;
      end else if (ld) begin
        mCnt = regWrData;
      end else if (runNow) begin
        if (tick) begin
          mPc = 0;
          mCnt = ((hit[0] && mMc[1]) || (hit[1] && mMc[4])) ? 0 : nx;
        end else mPc = mPc + 1;
      end
      if (regWrEn && regAddr == A_IST) mInt = mInt & ~regWrData[1:0];
      if (hit[0] && mMc[0]) mInt[0] = 1'b1;
      if (hit[1] && mMc[3]) mInt[1] = 1'b1;
      if (wrC) begin
        mRun = regWrData[0]; mClr = regWrData[1];
      end else if ((hit[0] && mMc[2]) || (hit[1] && mMc[5])) mRun = 0;
      if (regWrEn && regAddr == A_PRE)  mPre = regWrData;
      if (regWrEn && regAddr == A_MCTL) mMc = regWrData[5:0];
      if (regWrEn && regAddr == A_M0)   mMatch[0] = regWrData;
      if (regWrEn && regAddr == A_M1)   mMatch[1] = regWrData;
    end
  end

  function automatic bit [31:0] expRead(logic [3:0] a);
    case (a)
      A_CTRL: return {30'd0, mClr, mRun};
      A_PRE:  return mPre;
      A_PCNT: return mPc;
      A_CNT:  return mCnt;
      A_MCTL: return {26'd0, mMc};
      A_IST:  return {30'd0, mInt};
      A_M0:   return mMatch[0];
      A_M1:   return mMatch[1];
      default: return 32'd0;
    endcase
  endfunction

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (regRdData !== expRead(regAddr) || irq !== (mInt != 0)) begin
        errors++;
        $display("FAIL %s addr=%0d: actual rd=%h irq=%b expected rd=%h irq=%b",
                 curTag, regAddr, regRdData, irq, expRead(regAddr), (mInt != 0));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0; regAddr = A_CNT;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    // R1 reset
    idle(3);
    @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    @(posedge clk); #2 rstN = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v);
      chk("R1 register after reset", v, 32'd0);
    end

    // R3 prescale zero, R10 halt
    curTag = "R3";
    wr(A_CTRL, 1); idle(8); wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R3 step every clock", v, 32'd10);
    curTag = "R10";
    idle(3);
    rd(A_CNT, v); chk("R10 halted counter kept", v, 32'd10);
    curTag = "R3";
    wr(A_CTRL, 2); wr(A_CTRL, 0);
    wr(A_PRE, 3); wr(A_CTRL, 1); idle(18); wr(A_CTRL, 0);
    rd(A_CNT, v);  chk("R3 step every 4 clocks", v, 32'd5);
    rd(A_PCNT, v); chk("R3 prescale count wrapped", v, 32'd0);

    // R11 one-shot, R7 stop
    curTag = "R11";
    wr(A_CTRL, 2); wr(A_CTRL, 0);
    wr(A_PRE, 2); wr(A_M0, 1); wr(A_MCTL, 7); wr(A_CTRL, 1);
    idle(5);
    @(negedge clk); chk("R11 one-shot irq", {31'd0, irq}, 32'd1);
    rd(A_CNT, v);  chk("R11 counter zeroed", v, 32'd0);
    curTag = "R7";
    rd(A_CTRL, v); chk("R7 run cleared by hit", v, 32'd0);

    // R8 / R9 write-one-to-clear
    curTag = "R8";
    wr(A_IST, 0);
    rd(A_IST, v); chk("R8 zero write keeps flag", v, 32'd1);
    @(negedge clk); chk("R9 irq held", {31'd0, irq}, 32'd1);
    wr(A_IST, 1);
    rd(A_IST, v); chk("R8 one write clears flag", v, 32'd0);
    @(negedge clk); chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R12 load, R4 wrap
    curTag = "R12";
    wr(A_MCTL, 0); wr(A_PRE, 0); wr(A_CNT, 32'hFFFF_FFFE);
    rd(A_CNT, v); chk("R12 load", v, 32'hFFFF_FFFE);
    curTag = "R4";
    wr(A_CTRL, 1); idle(1); wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R4 wrap through zero", v, 32'd1);

    // R6 zero-on-hit, R5 flag on channel 1
    curTag = "R6";
    wr(A_CTRL, 2); wr(A_CTRL, 0);
    wr(A_M1, 4); wr(A_MCTL, 32'h18); wr(A_CTRL, 1); idle(8); wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R6 counter cycles 0..3", v, 32'd2);
    curTag = "R5";
    rd(A_IST, v); chk("R5 channel 1 flag", v, 32'd2);
    wr(A_IST, 3);

    // R2 clear hold and priority
    curTag = "R2";
    wr(A_CTRL, 3); idle(5);
    rd(A_CNT, v);  chk("R2 counter held", v, 32'd0);
    rd(A_PCNT, v); chk("R2 prescale held", v, 32'd0);
    wr(A_CTRL, 0);
    wr(A_PRE, 1); wr(A_CNT, 3); wr(A_M0, 4); wr(A_MCTL, 1);
    wr(A_CTRL, 1); wr(A_CTRL, 3);
    @(negedge clk); chk("R2 clear beats hit irq", {31'd0, irq}, 32'd0);
    rd(A_CNT, v);  chk("R2 clear beats hit count", v, 32'd0);
    curTag = "R5";
    wr(A_CTRL, 0); wr(A_CNT, 3); wr(A_CTRL, 1); idle(3);
    @(negedge clk); chk("R5 hit without clear", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 0);
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule